// File: doc/BRIEF.md
# Radix-4 Binary-Field Multiplier (Most Significant Digit First)

This block multiplies two elements of a binary extension field GF(2^M) held in polynomial basis, reducing modulo a caller-supplied irreducible polynomial N(x) of degree M. The degree is chosen per operation at run time, anywhere from 2 up to the datapath width `W`. The multiplier operand A is consumed two coefficients per clock, highest digit first. On every step the partial result is shifted up by two places, the addend is folded in with XOR, and a multiple g·N(x) with g in {0, 1, x, 1+x} cancels the two coefficients that would otherwise reach degree M and M+1.

All field values travel left-aligned in a `W`-bit word. Coefficient i of an M-degree field sits at bit `W-M+i`, and the bits under `W-M` are zero. Because of this, the reduction decision always reads the same few top bit positions whatever M is. Only the low M coefficients of N(x) are supplied; the leading x^M term is implied. One setup cycle builds and stores the doubled multiples. The reduction selector for each step is then produced and registered one cycle before the addend it drives, using only a narrow slice of the top bits of the partial result and the pending addend. The caller pulses `start` with valid operands and waits for `done`.

Top module: `gf4_msd_mult`

## Requirements
- R1: After reset `done` is 0 and `product` is 0.
- R2: When `done` is high, `product` equals A(x)·B(x) mod N(x), fully reduced, in the left-aligned format (coefficient i at bit `W-M+i`, bits below `W-M` zero). `op_a`, `op_b` and `poly` use the same format, `poly` holding the coefficients of degree 0 to M-1 of N(x) with x^M implied, and `deg` gives M in the range 2..`W`.
- R3: `done` rises exactly floor(M/2)+2 rising clock edges after the edge that samples `start` in the idle state, and stays low while an operation is in progress.
- R4: Once high, `done` and `product` hold their values until the next accepted `start`, which clears `done` at the edge that samples it.
- R5: Operands are captured at the accepted `start`. A `start` pulse or changed operand inputs during an operation have no effect: the result and the latency are those of the first request.
- R6: During every step the two coefficients shifted up to degree M and M+1 are cancelled, so the partial result never holds a coefficient of degree M or more.
- R7: Odd and even M are both handled. The first digit for even M is (0,0) and for odd M it is (0, A[M-1]), so operands such as A=0, B=0, A=1 and A=x give B·A mod N(x) exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only when idle |
| deg | input | $clog2(W+1) | Field degree M (2..W) |
| op_a | input | W | Multiplier A, left-aligned |
| op_b | input | W | Multiplicand B, left-aligned |
| poly | input | W | Low M coefficients of N(x), left-aligned |
| done | output | 1 | Result valid, held until the next accepted start |
| product | output | W | A·B mod N(x), left-aligned |

## Verification
The assertions take for granted that every accepted request has `deg` between 2 and `W`, that the bits of `op_a`, `op_b` and `poly` below position `W-M` are zero, and that `poly` describes an irreducible N(x). Under those conditions the cancellation of the two overflow coefficients holds on every step. The stimulus uses only fixed irreducible polynomials of degree 2, 7, 13 and 17. It builds each operand by masking random values to M bits and shifting them up by `W-M`, so the inputs never leave that envelope, including the operands changed in the middle of an operation.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

   typedef enum logic [1:0] {
      GFM_IDLE = 2'd0,
      GFM_PREP = 2'd1,
      GFM_RUN  = 2'd2
   } gfm_state_e;

   // Control for one step: digit of A and reduction multiple g = g1*x + g0
   typedef struct packed {
      logic a1;
      logic a0;
      logic g1;
      logic g0;
   } gfm_sel_t;

   // Choose g so that degree M+1 and M of the next partial result vanish.
   // t1/t0: coefficients that the shift will move to degree M+1 / M.
   function automatic gfm_sel_t gfm_pick(input logic t1, input logic t0,
                                         input logic a1, input logic a0,
                                         input logic btop, input logic ntop);
      gfm_sel_t s;
      s.a1 = a1;
      s.a0 = a0;
      s.g1 = t1;
      s.g0 = t0 ^ (a1 & btop) ^ (t1 & ntop);
      return s;
   endfunction

endpackage

// File: rtl/gfm_lookahead.sv
module gfm_lookahead
   import gfm_pkg::*;
(
   input  logic       prep,     // first selection: partial result is zero
   input  logic [1:0] x_mid,    // partial result bits W-3, W-4
   input  logic [1:0] add_hi,   // addend bits W-1, W-2 of the current step
   input  logic [1:0] digit,    // A digit used by the next step
   input  logic       btop,     // B coefficient M-1
   input  logic       ntop,     // N coefficient M-1
   output gfm_sel_t   sel_next
);

   logic t1;
   logic t0;

   // Top two bits of the partial result entering the next step, predicted
   // from narrow slices only
   always_comb begin
      if (prep) begin
         t1 = 1'b0;
         t0 = 1'b0;
      end else begin
         t1 = x_mid[1] ^ add_hi[1];
         t0 = x_mid[0] ^ add_hi[0];
      end
      sel_next = gfm_pick(t1, t0, digit[1], digit[0], btop, ntop);
   end

endmodule

// File: rtl/gfm_multiples.sv
module gfm_multiples
   import gfm_pkg::*;
#(
   parameter int unsigned W = 17,
   localparam int unsigned VW = W + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [W-1:0]  b_val,
   input  logic [W-1:0]  n_val,
   input  gfm_sel_t      sel,
   output logic [VW-1:0] addend
);

   logic [VW-1:0] b1_w;
   logic [VW-1:0] n1_w;
   logic [VW-1:0] b2_w;
   logic [VW-1:0] n2_w;
   logic [VW-1:0] bn1_q;   // B + N
   logic [VW-1:0] n2_q;    // 2N
   logic [VW-1:0] bn2_q;   // 2B + 2N

   // N carries its implied x^M term at bit W
   assign b1_w = {2'b00, b_val};
   assign n1_w = {2'b01, n_val};
   assign b2_w = {1'b0, b_val, 1'b0};
   assign n2_w = {1'b1, n_val, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bn1_q <= '0;
         n2_q  <= '0;
         bn2_q <= '0;
      end else if (load) begin
         bn1_q <= b1_w ^ n1_w;
         n2_q  <= n2_w;
         bn2_q <= b2_w ^ n2_w;
      end
   end

   // Bit-sliced selection: low mux picks from {0,B,N,B+N}, high mux from
   // {0,2B,2N,2B+2N}, combined with XOR
   for (genvar i = 0; i < VW; i++) begin : g_slice
      logic lo_bit;
      logic hi_bit;
      always_comb begin
         unique case ({sel.a0, sel.g0})
            2'b00:   lo_bit = 1'b0;
            2'b01:   lo_bit = n1_w[i];
            2'b10:   lo_bit = b1_w[i];
            default: lo_bit = bn1_q[i];
         endcase
         unique case ({sel.a1, sel.g1})
            2'b00:   hi_bit = 1'b0;
            2'b01:   hi_bit = n2_q[i];
            2'b10:   hi_bit = b2_w[i];
            default: hi_bit = bn2_q[i];
         endcase
      end
      assign addend[i] = lo_bit ^ hi_bit;
   end

endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl
   import gfm_pkg::*;
#(
   parameter int unsigned W = 17,
   localparam int unsigned MW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [MW-1:0] deg,
   input  logic [W-1:0]  op_a,
   output logic          accept,
   output logic          prep,
   output logic          run,
   output logic          done,
   output logic [1:0]    la_digit,
   output logic [MW-1:0] deg_q
);

   gfm_state_e     state_q;
   logic [MW-1:0]  cnt_q;
   logic [MW-1:0]  steps_q;
   logic [W+1:0]   sh_q;
   logic           done_q;

   assign accept = (state_q == GFM_IDLE) && start;
   assign prep   = (state_q == GFM_PREP);
   assign run    = (state_q == GFM_RUN);
   assign done   = done_q;

   // Setup selects for the first digit, each step for the following one
   assign la_digit = prep ? sh_q[W+1:W] : sh_q[W-1:W-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= GFM_IDLE;
         cnt_q   <= '0;
         steps_q <= '0;
         sh_q    <= '0;
         deg_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            GFM_IDLE: begin
               if (start) begin
                  state_q <= GFM_PREP;
                  done_q  <= 1'b0;
                  deg_q   <= deg;
                  cnt_q   <= '0;
                  steps_q <= MW'((deg >> 1) + 1'b1);
                  // odd degree: first digit is (0, A[M-1])
                  sh_q    <= deg[0] ? {1'b0, op_a, 1'b0} : {2'b00, op_a};
               end
            end
            GFM_PREP: begin
               state_q <= GFM_RUN;
            end
            GFM_RUN: begin
               sh_q <= sh_q << 2;
               if (MW'(cnt_q + 1'b1) == steps_q) begin
                  state_q <= GFM_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= GFM_IDLE;
         endcase
      end
   end

   AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != GFM_IDLE) |-> !done_q); // R3
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < steps_q)); // R3
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !accept) |=> ($stable(deg_q) && $stable(steps_q))); // R5
   AST_DEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ((deg >= MW'(2)) && (deg <= MW'(W)))); // R2

endmodule

// File: rtl/gf4_msd_mult.sv
module gf4_msd_mult
   import gfm_pkg::*;
#(
   parameter int unsigned W = 17,
   localparam int unsigned MW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [MW-1:0] deg,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   input  logic [W-1:0]  poly,
   output logic          done,
   output logic [W-1:0]  product
);

   localparam int unsigned VW = W + 2;

   if (W < 4) begin : g_bad_width
      $error("gf4_msd_mult: W must be at least 4");
   end

   logic          accept;
   logic          prep;
   logic          run;
   logic [1:0]    la_digit;
   logic [MW-1:0] deg_q;
   logic [W-1:0]  b_q;
   logic [W-1:0]  n_q;
   logic [W-1:0]  x_q;
   gfm_sel_t      sel_q;
   gfm_sel_t      sel_next;
   logic [VW-1:0] addend;
   logic [VW-1:0] wide;

   gfm_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .deg      (deg),
      .op_a     (op_a),
      .accept   (accept),
      .prep     (prep),
      .run      (run),
      .done     (done),
      .la_digit (la_digit),
      .deg_q    (deg_q)
   );

   gfm_multiples #(.W(W)) u_mult (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (prep),
      .b_val  (b_q),
      .n_val  (n_q),
      .sel    (sel_q),
      .addend (addend)
   );

   gfm_lookahead u_look (
      .prep     (prep),
      .x_mid    (x_q[W-3:W-4]),
      .add_hi   (addend[W-1:W-2]),
      .digit    (la_digit),
      .btop     (b_q[W-1]),
      .ntop     (n_q[W-1]),
      .sel_next (sel_next)
   );

   // Wired 2-place shift, then XOR with the selected addend
   assign wide = {x_q, 2'b00} ^ addend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q <= '0;
         n_q <= '0;
      end else if (accept) begin
         b_q <= op_b;
         n_q <= poly;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         sel_q <= '0;
      end else begin
         if (prep) begin
            x_q <= '0;
         end else if (run) begin
            x_q <= wide[W-1:0];
         end
         if (prep || run) begin
            sel_q <= sel_next;
         end
      end
   end

   assign product = x_q;

   AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (wide[VW-1:W] == 2'b00)); // R6
   AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((product << deg_q) == '0)); // R2
   AST_INPUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (((op_a << deg) == '0) && ((op_b << deg) == '0)
                  && ((poly << deg) == '0))); // R2
   AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !accept) |=> ($stable(b_q) && $stable(n_q))); // R5
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(product))); // R4

endmodule

// File: tb/gf4_msd_mult_test.sv
module gf4_msd_mult_test;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 17;
   localparam int MW = $clog2(W + 1);

   logic          clk;
   logic          rst_n;
   logic          start;
   logic [MW-1:0] deg;
   logic [W-1:0]  op_a;
   logic [W-1:0]  op_b;
   logic [W-1:0]  poly;
   logic          done;
   logic [W-1:0]  product;

   int checks = 0;
   int fails  = 0;

   gf4_msd_mult #(.W(W)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .deg     (deg),
      .op_a    (op_a),
      .op_b    (op_b),
      .poly    (poly),
      .done    (done),
      .product (product)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // Irreducible low parts: x^2+x+1, x^7+x+1, x^13+x^4+x^3+x+1, x^17+x^3+1
   localparam logic [31:0] N2  = 32'h3;
   localparam logic [31:0] N7  = 32'h3;
   localparam logic [31:0] N13 = 32'h1B;
   localparam logic [31:0] N17 = 32'h9;

   function automatic logic [31:0] ref_mul(input int m, input logic [31:0] n,
                                           input logic [31:0] a, input logic [31:0] b);
      logic [31:0] r;
      r = '0;
      for (int i = m - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[m]) r = r ^ ((32'd1 << m) | n);
         if (a[i]) r = r ^ b;
      end
      return r;
   endfunction

   function automatic logic [W-1:0] align(input logic [31:0] v, input int m);
      logic [31:0] s;
      s = v << (W - m);
      return s[W-1:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One multiply; optionally a second start with other operands mid-run
   task automatic run_mul(input int m, input logic [31:0] n, input logic [31:0] a,
                          input logic [31:0] b, input string req, input bit disturb);
      int c;
      logic [31:0] exp;
      exp = ref_mul(m, n, a, b);
      @(negedge clk);
      deg   = MW'(m);
      op_a  = align(a, m);
      op_b  = align(b, m);
      poly  = align(n, m);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      c = 0;
      check("R4", 32'(done), 32'd0, "done cleared by accepted start");
      while (!done && c < 100) begin
         if (disturb && c == 2) begin
            op_a  = align(~a, m);
            op_b  = align(b ^ 32'h5, m);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         c++;
      end
      start = 1'b0;
      check("R3", 32'(c), 32'(m / 2 + 2), "latency in cycles");
      check(req, 32'(product), 32'(align(exp, m)), "product");
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      start = 1'b0;
      deg   = '0;
      op_a  = '0;
      op_b  = '0;
      poly  = '0;
      repeat (3) @(negedge clk);
      check("R1", 32'(done), 32'd0, "done after reset");
      check("R1", 32'(product), 32'd0, "product after reset");
      rst_n = 1'b1;
   endtask

   task automatic test_corners();
      int ms[4] = '{2, 7, 13, 17};
      logic [31:0] ns[4] = '{N2, N7, N13, N17};
      for (int k = 0; k < 4; k++) begin
         int m = ms[k];
         logic [31:0] full = (32'd1 << m) - 1;
         logic [31:0] rb = $urandom & full;
         run_mul(m, ns[k], 32'd0, rb, "R7", 1'b0);            // A = 0
         run_mul(m, ns[k], rb, 32'd0, "R7", 1'b0);            // B = 0
         run_mul(m, ns[k], 32'd1, rb, "R7", 1'b0);            // A = 1
         run_mul(m, ns[k], 32'd2, 32'd1 << (m - 1), "R7", 1'b0); // x * x^(M-1)
         run_mul(m, ns[k], full, full, "R6", 1'b0);           // all ones
      end
   endtask

   task automatic test_random(input int m, input logic [31:0] n, input int count);
      logic [31:0] full = (32'd1 << m) - 1;
      for (int k = 0; k < count; k++) begin
         run_mul(m, n, $urandom & full, $urandom & full, "R2", 1'b0);
      end
   endtask

   task automatic test_hold();
      logic [W-1:0] held;
      run_mul(13, N13, 32'h1A5B, 32'h0F3C, "R2", 1'b0);
      held = product;
      op_a = '1;
      op_b = '1;
      repeat (4) @(negedge clk);
      check("R4", 32'(done), 32'd1, "done held");
      check("R4", 32'(product), 32'(held), "product held");
   endtask

   task automatic test_busy_start();
      run_mul(17, N17, 32'h1ACE1, 32'h0BEEF, "R5", 1'b1);
      run_mul(7, N7, 32'h55, 32'h2B, "R5", 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      test_reset();
      test_corners();
      test_random(2, N2, 4);
      test_random(7, N7, 10);
      test_random(13, N13, 10);
      test_random(17, N17, 10);
      test_hold();
      test_busy_start();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule